// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a single-rank SDRAM. After reset it drives the command pins through the power-up sequence. That sequence is a long NOP pause with the clock enable high, a precharge of every bank, a run of auto refreshes, and a load of the mode register from a configuration word. Once the sequence is done it raises `ready` and takes on periodic refresh for the rest of the session. Data transfers and the choice of who owns the command bus are left to a surrounding arbiter.

In normal operation an interval timer adds one owed refresh every `REFI_CYC` cycles. The number of owed refreshes is held in a small saturating counter. A refresh request and grant pair behaves like a valid/ready handshake. `ref_req` is the valid side and `ref_gnt` is the ready side, and a refresh is committed on any rising edge where both are high. Once `ref_req` rises it stays high until a handshake takes place, so the arbiter may hold off for as long as it likes. A grant offered while `ref_req` is low does nothing. `ref_urgent` tells the arbiter that the backlog has grown past eight. Clock frequency is a parameter, and the pause count and the refresh interval are derived from it.

Command encodings on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} are: NOP 0111, precharge 0010, auto refresh 0001, mode set 0000. Cycle numbering used below: cycle 1 is the cycle after the first rising edge with `rst_n` high. With default parameters PAUSE_CYC = 25000, TRP_CYC = 3, TRC_CYC = 9, TMRD_CYC = 2 and REFI_CYC = 1953.

Top module: `sdr_init_refresh`

## Requirements
- R1: While in reset and during cycles 1 to PAUSE_CYC-1, `sd_cke` is 1, the pins carry NOP (0111) and `sd_addr` is 0. In cycle PAUSE_CYC the pins carry precharge (0010) with `sd_addr` bit 10 set and all other address bits 0.
- R2: Exactly 8 auto refresh commands (0001) follow during initialization. The first comes TRP_CYC cycles after the precharge and each later one comes TRC_CYC cycles after the one before.
- R3: A mode set (0000) comes TRC_CYC cycles after the last initialization refresh. `sd_addr` then holds bits 2..0 = `cfg_burst_len`, bit 3 = `cfg_interleave`, bits 6..4 = `cfg_cas_lat`, bits 9..7 = 100 when `cfg_single_write` is 1 and 000 otherwise, and bits 11..10 = 0.
- R4: `ready` is 0 from reset until TMRD_CYC cycles after the mode set, with only NOPs between. It is 1 from that cycle until the next reset.
- R5: Once `ready` is high, one refresh becomes owed every REFI_CYC cycles. The first becomes visible as `ref_req` REFI_CYC cycles after the first ready cycle. The owed count saturates at 15.
- R6: `ref_req` is 1 exactly when `ready` is 1, at least one refresh is owed, and at least TRC_CYC-1 cycles have passed since the last refresh command cycle. Granting at the first chance therefore spaces refreshes exactly TRC_CYC apart.
- R7: When `ref_req` and `ref_gnt` are both 1 at a rising edge, the next cycle carries an auto refresh with `sd_addr` 0 and the owed count drops by one. If an interval expires at that same edge, the owed count stays unchanged.
- R8: A `ref_gnt` while `ref_req` is 0, including throughout initialization, has no effect. The pins stay at NOP and no refresh is issued.
- R9: `ref_urgent` is 1 exactly when more than 8 refreshes are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Burst length code placed on address bits 2..0 at mode set |
| cfg_interleave | input | 1 | Burst type placed on address bit 3 (1 = interleave) |
| cfg_cas_lat | input | 3 | CAS latency code placed on address bits 6..4 |
| cfg_single_write | input | 1 | Selects burst reads with single writes (bits 9..7 = 100) |
| ref_gnt | input | 1 | Arbiter grant, ready side of the refresh handshake |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins, bit 11 = bank select |
| ready | output | 1 | Initialization complete |
| ref_req | output | 1 | Refresh wanted, valid side of the handshake |
| ref_urgent | output | 1 | More than 8 refreshes owed |

## Verification
The interval timer can add an owed refresh at the same edge where a handshake removes one, and both updates land on the same counter. The bench provokes this by offering `ref_gnt` only in the cycles where an interval expires, and then checks that `ref_req` returns once the TRC window closes, since a count of one was neither lost nor doubled. It also tracks the owed count through long grant droughts, saturation and bursts of granted refreshes. Every cycle, it compares `ref_req`, `ref_urgent` and the command pins against its own model of the count and of the spacing.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  localparam int SD_ADDR_W   = 12;
  localparam int PRE_ALL_BIT = 10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sd_cmd_t;
  localparam sd_cmd_t CMD_NOP = 4'b0111;
  localparam sd_cmd_t CMD_PRE = 4'b0010;
  localparam sd_cmd_t CMD_REF = 4'b0001;
  localparam sd_cmd_t CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    S_PAUSE, S_PRE, S_IREF, S_MRS, S_WAIT, S_IDLE, S_RREF
  } seq_st_t;

  function automatic logic [SD_ADDR_W-1:0] pack_mode(
    input logic [2:0] blen, input logic ilv,
    input logic [2:0] clat, input logic swr);
    return {2'b00, swr, 2'b00, clat, ilv, blen};
  endfunction

endpackage

// File: rtl/sdr_interval_timer.sv
module sdr_interval_timer #(
  parameter int PERIOD = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sdr_refresh_ledger.sv
module sdr_refresh_ledger #(
  parameter int PEND_W       = 4,
  parameter int URGENT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add_one,
  input  logic take_one,
  output logic owed_nz,
  output logic urgent
);
  localparam int PEND_MAX = (1 << PEND_W) - 1;

  logic [PEND_W-1:0] owed;

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (add_one && !take_one && owed != PEND_W'(PEND_MAX)) owed <= owed + 1'b1;
    else if (take_one && !add_one) owed <= owed - 1'b1;
  end

  assign owed_nz = (owed != '0);

  generate
    if (URGENT_LIMIT >= PEND_MAX) begin : g_never
      assign urgent = 1'b0;
    end else begin : g_cmp
      assign urgent = (owed > PEND_W'(URGENT_LIMIT));
    end
  endgenerate
endmodule

// File: rtl/sdr_cmd_sequencer.sv
module sdr_cmd_sequencer
  import sdr_seq_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 9,
  parameter int TMRD_CYC  = 2,
  parameter int INIT_REFS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 owed_nz,
  input  logic                 ref_gnt,
  input  logic [SD_ADDR_W-1:0] mode_word,
  output sd_cmd_t              cmd,
  output logic [SD_ADDR_W-1:0] addr,
  output logic                 run,
  output logic                 ref_req,
  output logic                 issue
);
  localparam int CNT_W = $clog2(PAUSE_CYC + 1);
  localparam int NR_W  = $clog2(INIT_REFS + 1);
  localparam logic [CNT_W-1:0] GAP_RP = CNT_W'(TRP_CYC - 2);
  localparam logic [CNT_W-1:0] GAP_RC = CNT_W'(TRC_CYC - 2);
  localparam logic [CNT_W-1:0] GAP_MR = CNT_W'(TMRD_CYC - 2);

  seq_st_t          st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [NR_W-1:0]  nref;
  logic             run_q;

  assign run     = run_q;
  assign ref_req = run_q && owed_nz &&
                   (st == S_IDLE || (st == S_WAIT && cnt == '0));
  assign issue   = ref_req && ref_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      nxt   <= S_IDLE;
      cnt   <= CNT_W'(PAUSE_CYC - 1);
      nref  <= '0;
      run_q <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: if (cnt == '0) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE: begin
          st <= S_WAIT; cnt <= GAP_RP; nxt <= S_IREF;
        end
        S_IREF: begin
          st   <= S_WAIT;
          cnt  <= GAP_RC;
          nref <= nref + 1'b1;
          nxt  <= (nref == NR_W'(INIT_REFS - 1)) ? S_MRS : S_IREF;
        end
        S_MRS: begin
          st <= S_WAIT; cnt <= GAP_MR; nxt <= S_IDLE;
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (issue) st <= S_RREF;
          else begin
            st <= nxt;
            if (nxt == S_IDLE) run_q <= 1'b1;
          end
        end
        S_IDLE: if (issue) st <= S_RREF;
        S_RREF: begin
          st <= S_WAIT; cnt <= GAP_RC; nxt <= S_IDLE;
        end
        default: st <= S_PAUSE;
      endcase
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    case (st)
      S_PRE: begin
        cmd = CMD_PRE;
        addr[PRE_ALL_BIT] = 1'b1;
      end
      S_IREF, S_RREF: cmd = CMD_REF;
      S_MRS: begin
        cmd  = CMD_MRS;
        addr = mode_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int PAUSE_US     = 200,
  parameter int REFI_NS      = 15625,
  parameter int TRP_CYC      = 3,
  parameter int TRC_CYC      = 9,
  parameter int TMRD_CYC     = 2,
  parameter int INIT_REFS    = 8,
  parameter int PEND_W       = 4,
  parameter int URGENT_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_burst_len,
  input  logic        cfg_interleave,
  input  logic [2:0]  cfg_cas_lat,
  input  logic        cfg_single_write,
  input  logic        ref_gnt,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [11:0] sd_addr,
  output logic        ready,
  output logic        ref_req,
  output logic        ref_urgent
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int REFI_CYC  = (CLK_MHZ * REFI_NS) / 1000;

  logic    tick, issue, owed_nz, run;
  sd_cmd_t cmd;

  sdr_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  sdr_refresh_ledger #(.PEND_W(PEND_W), .URGENT_LIMIT(URGENT_LIMIT)) u_ledger (
    .clk(clk), .rst_n(rst_n), .add_one(tick), .take_one(issue),
    .owed_nz(owed_nz), .urgent(ref_urgent)
  );

  sdr_cmd_sequencer #(
    .PAUSE_CYC(PAUSE_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
    .TMRD_CYC(TMRD_CYC), .INIT_REFS(INIT_REFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .ref_gnt(ref_gnt),
    .mode_word(pack_mode(cfg_burst_len, cfg_interleave, cfg_cas_lat, cfg_single_write)),
    .cmd(cmd), .addr(sd_addr), .run(run), .ref_req(ref_req), .issue(issue)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke = 1'b1;
  assign ready  = run;
endmodule

// File: rtl/sdr_init_refresh_chk.sv
module sdr_init_refresh_chk
  import sdr_seq_pkg::*;
#(
  parameter int TRC_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic ready,
  input logic ref_req,
  input logic ref_gnt,
  input logic ref_urgent
);
  localparam int SW = $clog2(TRC_CYC + 1);

  sd_cmd_t        pins;
  logic           is_ref;
  logic [SW-1:0]  since_ref;

  assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_ref = (pins == CMD_REF);

  always_ff @(posedge clk) begin
    if (!rst_n)                        since_ref <= SW'(TRC_CYC);
    else if (is_ref)                   since_ref <= '0;
    else if (since_ref < SW'(TRC_CYC)) since_ref <= since_ref + 1'b1;
  end

  a_r2_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> since_ref >= SW'(TRC_CYC - 1));
  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r6_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready);
  a_r7_handshake_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> is_ref);
  a_r8_ref_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && ready) |-> $past(ref_req && ref_gnt));
  a_r9_urgent_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ready);
endmodule

bind sdr_init_refresh sdr_init_refresh_chk #(.TRC_CYC(TRC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .ready(ready), .ref_req(ref_req),
  .ref_gnt(ref_gnt), .ref_urgent(ref_urgent)
);

// File: tb/tb_sdr_init_refresh.sv
module tb_sdr_init_refresh;
  localparam int PAUSE_C = 25000;
  localparam int REFI_C  = 1953;
  localparam int TRP     = 3;
  localparam int TRC     = 9;
  localparam int TMRD    = 2;
  localparam int NOP = 7, PRE = 2, REF = 1, MRS = 0;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic [2:0] cfg_bl = 0, cfg_cl = 0;
  logic cfg_il = 0, cfg_sw = 0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready, ref_req, ref_urgent;
  logic [11:0] sd_addr;

  always #4 clk = ~clk;

  sdr_init_refresh dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
    .cfg_cas_lat(cfg_cl), .cfg_single_write(cfg_sw), .ref_gnt(ref_gnt),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .ready(ready), .ref_req(ref_req),
    .ref_urgent(ref_urgent)
  );

  int errs = 0, checks = 0;
  int t, R, pnd, last_ref, ref_seen, coinc, first_req;
  bit hs_prev, done = 0;

  function automatic int pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic int want_mode(input int bl, il, cl, sw);
    return (sw ? (4 << 7) : 0) + (cl << 4) + (il << 3) + bl;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_init(input int bl, il, cl, sw);
    int mrs_t, k, e;
    string tg;
    cfg_bl = 3'(bl); cfg_il = il[0]; cfg_cl = 3'(cl); cfg_sw = sw[0];
    rst_n = 0; ref_gnt = 0;
    repeat (4) @(negedge clk);
    chk(pins() == NOP && sd_cke, "R1", "reset cmd", pins(), NOP);
    chk(!ready, "R4", "ready in reset", ready, 0);
    chk(!ref_req, "R6", "req in reset", ref_req, 0);
    chk(!ref_urgent, "R9", "urgent in reset", ref_urgent, 0);
    rst_n = 1;
    mrs_t = PAUSE_C + TRP + 8 * TRC;
    R = mrs_t + TMRD;
    for (int i = 1; i <= R; i++) begin
      @(negedge clk);
      t = i;
      k = i - PAUSE_C - TRP;
      if (i == PAUSE_C) begin e = PRE; tg = "R1"; end
      else if (k >= 0 && k % TRC == 0 && k / TRC < 8) begin e = REF; tg = "R2"; end
      else if (i == mrs_t) begin e = MRS; tg = "R3"; end
      else begin e = NOP; tg = ref_gnt ? "R8" : (i < PAUSE_C ? "R1" : "R4"); end
      chk(pins() == e, tg, "init cmd", pins(), e);
      chk(sd_cke == 1'b1, "R1", "cke", sd_cke, 1);
      if (e == PRE) chk(sd_addr == 12'h400, "R1", "precharge addr", sd_addr, 12'h400);
      else if (e == MRS) chk(int'(sd_addr) == want_mode(bl, il, cl, sw), "R3",
                             "mode word", sd_addr, want_mode(bl, il, cl, sw));
      else chk(sd_addr == 0, tg, "addr", sd_addr, 0);
      chk(ready == (i >= R), "R4", "ready", ready, int'(i >= R));
      chk(!ref_req, "R6", "req during init", ref_req, 0);
      ref_gnt = (i == R) ? 1'b0 : 1'($urandom % 2);
    end
    pnd = 0; last_ref = -100000; hs_prev = 0; first_req = -1;
  endtask

  // mode 0: never grant, 1: always, 2: random, 3: grant only on interval cycles
  task automatic run(input int mode, input int n);
    bit er, tk, hs;
    int e;
    for (int i = 0; i < n; i++) begin
      t++;
      @(negedge clk);
      er = (pnd != 0) && (t - last_ref >= TRC - 1);
      e  = hs_prev ? REF : NOP;
      chk(pins() == e, hs_prev ? "R7" : "R8", "run cmd", pins(), e);
      chk(sd_addr == 0, "R7", "run addr", sd_addr, 0);
      chk(ready, "R4", "ready held", ready, 1);
      chk(ref_req == er, "R6", "ref_req", ref_req, er);
      chk(ref_urgent == (pnd > 8), "R9", "urgent", ref_urgent, int'(pnd > 8));
      if (pins() == REF) ref_seen++;
      if (ref_req && first_req < 0) first_req = t;
      tk = ((t - R) % REFI_C) == REFI_C - 1;
      case (mode)
        0: ref_gnt = 0;
        1: ref_gnt = 1;
        2: ref_gnt = ($urandom % 4) == 0;
        default: ref_gnt = tk;
      endcase
      hs = er && ref_gnt;
      if (hs && tk) coinc++;
      if (tk && !hs && pnd < 15) pnd++;
      else if (hs && !tk) pnd--;
      if (hs) last_ref = t + 1;
      hs_prev = hs;
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    begin
      int bls[5] = '{0, 1, 2, 3, 7};
      do_init(bls[$urandom % 5], $urandom % 2, 2 + $urandom % 2, $urandom % 2);
    end
    run(0, 16 * REFI_C);
    chk(first_req == R + REFI_C, "R5", "first request cycle", first_req, R + REFI_C);
    chk(ref_urgent, "R9", "urgent after drought", ref_urgent, 1);
    ref_seen = 0;
    run(1, 200);
    chk(ref_seen == 15, "R5", "refreshes drained at saturation", ref_seen, 15);
    coinc = 0;
    run(3, 4 * REFI_C);
    chk(coinc >= 2, "R7", "grant coincident with interval", coinc, 2);
    run(2, 6 * REFI_C);
    do_init(7, 0, 3, 1);
    run(2, 2 * REFI_C);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule